// File: doc/BRIEF.md
# Multi-Mode Timer/Counter Channel

This block is one timer/counter channel for a small 8-bit controller. Two count bytes, a low and a high, are read and written through a simple register port. A mode field decides how the pair counts: as one 13-bit count, as one 16-bit count, as an 8-bit count that reloads itself from the high byte, or as two independent 8-bit counts. The count only ever goes up.

In timer mode the channel advances once per machine cycle. A machine cycle is a fixed number of clock cycles set by a parameter, 12 by default. In counter mode it advances on falling edges of an event pin instead. A gate option lets a second pin hold counting off while that pin is low. A run bit starts and stops the count. An overflow flag records each wrap until software or an acknowledge pulse clears it. In split mode the high byte counts machine cycles under its own run bit and sets a flag of its own.

Top module: `tmr_unit`

## Requirements
- R1: After reset, the low byte, the high byte, the control byte and both flags read 0.
- R2: With the run bit (control bit 0) set, timer source selected (control bit 3 = 0) and no gating, the count advances by exactly one every CYCLE_DIV clock cycles, where machine-cycle ticks come from a free-running divider. With the run bit clear, the count holds.
- R3: In mode 1 (control bits 2:1 = 01), the high and low bytes form one 16-bit count with the high byte on top. Going from FFFFh to 0000h sets the main overflow flag in the same cycle.
- R4: In mode 0, only the lower LOW13_BITS (default 5) bits of the low byte count. A carry out of that field increments the high byte, and the upper bits of the low byte hold their value. The main flag is set when the high byte is FFh and the field is all ones as the count steps.
- R5: In mode 2, only the low byte counts. When it steps from FFh, it is loaded with the high byte in the same cycle that the main flag is set, and the high byte is unchanged.
- R6: In mode 3, the low byte counts under the main run, source and gate controls and sets the main flag on its wrap. The high byte counts machine-cycle ticks while the auxiliary run bit (control bit 6) is set, and its wrap from FFh sets the auxiliary flag.
- R7: With control bit 3 = 1, the count advances once for each 1-to-0 change of the event pin, as seen on two consecutive ticks. A pulse whose high and low phases each cover at least one tick adds exactly one, and a steady pin adds nothing.
- R8: With gating enabled (control bit 4 = 1), the count advances only while the gate pin is high. With gating off, the gate pin has no effect.
- R9: The main flag (control bit 5) is cleared by a control write with bit 5 = 0 or by an acknowledge pulse. The auxiliary flag (control bit 7) is cleared by a control write with bit 7 = 0. Writing 1 to either bit leaves it unchanged, and an overflow in the same cycle as a clear leaves the flag set.
- R10: Register addresses are 0 for the low byte, 1 for the high byte and 2 for the control byte {auxFlag, auxRun, mainFlag, gate, source, mode[1:0], run}. Address 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for reads and writes |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| evtPin | input | 1 | External event input for counter source |
| gatePin | input | 1 | External gate input |
| ackOvf | input | 1 | Acknowledge pulse that clears the main flag |
| ovfFlag | output | 1 | Main overflow flag |
| ovfAuxFlag | output | 1 | Auxiliary (split-mode high byte) overflow flag |

## Verification
The bound checker watches every cycle for properties that follow from the mode alone. In 16-bit mode the count steps by exactly one and a new flag coincides with a zero count. In reload mode a new flag coincides with the low byte equalling the high byte. A stopped channel keeps its low byte, the upper bits of the low byte hold in 13-bit mode, and a flag stays set until it is cleared. Other behaviours can only be shown by the bench's scenarios: the exact tick rate, one count per pulse on the event pin, gating, split-mode independence, and a clear landing in the same cycle as an overflow, which the bench reaches by lining its writes up with the observed tick phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_13     = 2'd0,
    MODE_16     = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tmrMode_e;

  localparam logic [1:0] ADDR_LOW  = 2'd0;
  localparam logic [1:0] ADDR_HIGH = 2'd1;
  localparam logic [1:0] ADDR_CTL  = 2'd2;

  localparam int CTL_RUN     = 0;
  localparam int CTL_MODE    = 1;
  localparam int CTL_SRC     = 3;
  localparam int CTL_GATE    = 4;
  localparam int CTL_OVF     = 5;
  localparam int CTL_RUNAUX  = 6;
  localparam int CTL_OVFAUX  = 7;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic     stepMain;
    logic     stepAux;
    logic     wrLow;
    logic     wrHigh;
    logic     clrMain;
    logic     clrAux;
    tmrMode_e mode;
  } tmrStrobe_t;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int unsigned CYCLE_DIV = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  input  logic              evtPin,
  input  logic              gatePin,
  input  logic              ackOvf,
  output tmrStrobe_t        strobe,
  output logic              ctlRun,
  output tmrMode_e          ctlMode,
  output logic              ctlSrc,
  output logic              ctlGate,
  output logic              ctlRunAux
);

  logic tick;

  // machine-cycle tick: divider variant chosen by parameter
  generate
    if (CYCLE_DIV < 2) begin : g_noDiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(CYCLE_DIV);
      localparam logic [PW-1:0] LAST = PW'(CYCLE_DIV - 1);
      logic [PW-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rstN)       divCnt <= '0;
        else if (tick)   divCnt <= '0;
        else             divCnt <= divCnt + PW'(1);
      end
      assign tick = (divCnt == LAST);
    end
  endgenerate

  // event pin sampled once per tick; falling edge across two samples
  logic pinSample;
  always_ff @(posedge clk) begin
    if (!rstN)     pinSample <= 1'b0;
    else if (tick) pinSample <= evtPin;
  end

  logic evtStep;
  assign evtStep = tick && pinSample && !evtPin;

  logic wrCtl;
  assign wrCtl = regWrEn && (regAddr == ADDR_CTL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlRun    <= 1'b0;
      ctlMode   <= MODE_13;
      ctlSrc    <= 1'b0;
      ctlGate   <= 1'b0;
      ctlRunAux <= 1'b0;
    end else if (wrCtl) begin
      ctlRun    <= regWrData[CTL_RUN];
      ctlMode   <= tmrMode_e'(regWrData[CTL_MODE +: 2]);
      ctlSrc    <= regWrData[CTL_SRC];
      ctlGate   <= regWrData[CTL_GATE];
      ctlRunAux <= regWrData[CTL_RUNAUX];
    end
  end

  logic srcPulse;
  logic gateOpen;
  assign srcPulse = ctlSrc ? evtStep : tick;
  assign gateOpen = !ctlGate || gatePin;

  always_comb begin
    strobe.stepMain = ctlRun && gateOpen && srcPulse;
    strobe.stepAux  = ctlRunAux && tick;
    strobe.wrLow    = regWrEn && (regAddr == ADDR_LOW);
    strobe.wrHigh   = regWrEn && (regAddr == ADDR_HIGH);
    strobe.clrMain  = (wrCtl && !regWrData[CTL_OVF]) || ackOvf;
    strobe.clrAux   = wrCtl && !regWrData[CTL_OVFAUX];
    strobe.mode     = ctlMode;
  end

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int unsigned LOW13_BITS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] lowQ,
  output logic [BYTE_W-1:0] highQ,
  output logic              ovfQ,
  output logic              ovfAuxQ
);

  localparam int WIDE_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] FIELD_MASK =
    (BYTE_W'(1) << LOW13_BITS) - BYTE_W'(1);

  logic [BYTE_W-1:0] nextLow;
  logic [BYTE_W-1:0] nextHigh;
  logic [WIDE_W-1:0] wideNext;
  logic              wrapMain;
  logic              wrapAux;

  assign wideNext = {highQ, lowQ} + WIDE_W'(1);

  always_comb begin
    nextLow  = lowQ;
    nextHigh = highQ;
    wrapMain = 1'b0;
    wrapAux  = 1'b0;
    unique case (strobe.mode)
      MODE_13: begin
        if (strobe.stepMain) begin
          if ((lowQ & FIELD_MASK) == FIELD_MASK) begin
            nextLow  = lowQ & ~FIELD_MASK;
            nextHigh = highQ + BYTE_W'(1);
            wrapMain = &highQ;
          end else begin
            nextLow  = lowQ + BYTE_W'(1);
          end
        end
      end
      MODE_16: begin
        if (strobe.stepMain) begin
          {nextHigh, nextLow} = wideNext;
          wrapMain = &{highQ, lowQ};
        end
      end
      MODE_RELOAD: begin
        if (strobe.stepMain) begin
          if (&lowQ) begin
            nextLow  = highQ;
            wrapMain = 1'b1;
          end else begin
            nextLow  = lowQ + BYTE_W'(1);
          end
        end
      end
      MODE_SPLIT: begin
        if (strobe.stepMain) begin
          nextLow  = lowQ + BYTE_W'(1);
          wrapMain = &lowQ;
        end
        if (strobe.stepAux) begin
          nextHigh = highQ + BYTE_W'(1);
          wrapAux  = &highQ;
        end
      end
      default: ;
    endcase
  end

  // a register write owns its byte for that cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowQ  <= '0;
      highQ <= '0;
    end else begin
      lowQ  <= strobe.wrLow  ? wrData : nextLow;
      highQ <= strobe.wrHigh ? wrData : nextHigh;
    end
  end

  // overflow beats a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfQ    <= 1'b0;
      ovfAuxQ <= 1'b0;
    end else begin
      if (wrapMain)            ovfQ <= 1'b1;
      else if (strobe.clrMain) ovfQ <= 1'b0;
      if (wrapAux)             ovfAuxQ <= 1'b1;
      else if (strobe.clrAux)  ovfAuxQ <= 1'b0;
    end
  end

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int unsigned CYCLE_DIV  = 12,
  parameter int unsigned LOW13_BITS = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       evtPin,
  input  logic       gatePin,
  input  logic       ackOvf,
  output logic       ovfFlag,
  output logic       ovfAuxFlag
);

  tmrStrobe_t        strobe;
  logic              ctlRun;
  tmrMode_e          ctlMode;
  logic              ctlSrc;
  logic              ctlGate;
  logic              ctlRunAux;
  logic [BYTE_W-1:0] cntLow;
  logic [BYTE_W-1:0] cntHigh;

  tmr_ctrl #(.CYCLE_DIV(CYCLE_DIV)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .evtPin    (evtPin),
    .gatePin   (gatePin),
    .ackOvf    (ackOvf),
    .strobe    (strobe),
    .ctlRun    (ctlRun),
    .ctlMode   (ctlMode),
    .ctlSrc    (ctlSrc),
    .ctlGate   (ctlGate),
    .ctlRunAux (ctlRunAux)
  );

  tmr_datapath #(.LOW13_BITS(LOW13_BITS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (regWrData),
    .lowQ    (cntLow),
    .highQ   (cntHigh),
    .ovfQ    (ovfFlag),
    .ovfAuxQ (ovfAuxFlag)
  );

  always_comb begin
    unique case (regAddr)
      ADDR_LOW:  regRdData = cntLow;
      ADDR_HIGH: regRdData = cntHigh;
      ADDR_CTL:  regRdData = {ovfAuxFlag, ctlRunAux, ovfFlag, ctlGate,
                              ctlSrc, ctlMode, ctlRun};
      default:   regRdData = '0;
    endcase
  end

endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int unsigned LOW13_BITS = 5
) (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic       ackOvf,
  input logic       ovfFlag,
  input logic [7:0] lowByte,
  input logic [7:0] highByte,
  input logic       runBit,
  input logic [1:0] mode
);

  localparam logic [7:0] HOLD_MASK = ~((8'd1 << LOW13_BITS) - 8'd1);

  // R2: stopped channel keeps its low byte
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(runBit) && !$past(regWrEn)) |-> $stable(lowByte));

  // R3: 16-bit count steps by one
  p_step16_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1 && $past(mode) == 2'd1 && !$past(regWrEn) &&
     {highByte, lowByte} != $past({highByte, lowByte}))
    |-> {highByte, lowByte} == $past({highByte, lowByte}) + 16'd1);

  // R3: new flag in 16-bit mode means a zero count
  p_wrap16_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1 && $past(mode) == 2'd1 && !$past(regWrEn) && $rose(ovfFlag))
    |-> ({highByte, lowByte} == 16'd0));

  // R4: upper bits of low byte hold in 13-bit mode
  p_upper13_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && $past(mode) == 2'd0 && !$past(regWrEn))
    |-> ((lowByte & HOLD_MASK) == ($past(lowByte) & HOLD_MASK)));

  // R5: reload coincides with flag
  p_reload_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2 && $past(mode) == 2'd2 && !$past(regWrEn) && $rose(ovfFlag))
    |-> (lowByte == highByte));

  // R9: flag stays until cleared
  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ovfFlag) && !$past(ackOvf) && !$past(regWrEn)) |-> ovfFlag);

endmodule

bind tmr_unit tmr_unit_chk #(.LOW13_BITS(LOW13_BITS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .ackOvf   (ackOvf),
  .ovfFlag  (ovfFlag),
  .lowByte  (cntLow),
  .highByte (cntHigh),
  .runBit   (ctlRun),
  .mode     (ctlMode)
);

// File: tb/sim_tmr_unit.sv
module sim_tmr_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       evtPin = 1'b1;
  logic       gatePin = 1'b0;
  logic       ackOvf = 1'b0;
  logic       ovfFlag;
  logic       ovfAuxFlag;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tmr_unit u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evtPin(evtPin),
    .gatePin(gatePin), .ackOvf(ackOvf), .ovfFlag(ovfFlag),
    .ovfAuxFlag(ovfAuxFlag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ctlb(input logic run, input logic [1:0] mode,
      input logic src, input logic gate, input logic runAux,
      input logic keepOvf, input logic keepAux);
    return {keepAux, runAux, keepOvf, gate, src, mode, run};
  endfunction

  // drive now, release at next falling edge
  task automatic driveWr(input logic [1:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    driveWr(a, d);
  endtask

  task automatic ackNow();
    ackOvf = 1'b1;
    @(negedge clk);
    ackOvf = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic readCount(output int v);
    logic [7:0] lo, hi;
    regRead(2'd0, lo);
    regRead(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic waitFlag(input bit aux, input int maxCyc, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < maxCyc; i++) begin
      @(negedge clk);
      if ((aux ? ovfAuxFlag : ovfFlag) == 1'b1) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic stopAll();
    regWrite(2'd2, ctlb(1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
  endtask

  task automatic t_reset();
    logic [7:0] d;
    regRead(2'd0, d); chk("R1 low", d, 0);
    regRead(2'd1, d); chk("R1 high", d, 0);
    regRead(2'd2, d); chk("R1 ctl", d, 0);
    chk("R1 ovf", ovfFlag, 0);
    chk("R1 ovfAux", ovfAuxFlag, 0);
  endtask

  task automatic t_map();
    logic [7:0] d;
    regWrite(2'd0, 8'h12);
    regWrite(2'd1, 8'h34);
    regWrite(2'd3, 8'hFF);
    regRead(2'd3, d); chk("R10 addr3 reads 0", d, 0);
    regRead(2'd0, d); chk("R10 low kept", d, 8'h12);
    regRead(2'd1, d); chk("R10 high kept", d, 8'h34);
    regRead(2'd2, d); chk("R10 ctl kept", d, 0);
    regWrite(2'd2, ctlb(1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1));
    regRead(2'd2, d); chk("R10 ctl layout", d, 8'h1C);
    stopAll();
  endtask

  task automatic t_rate();
    int v0, v1;
    regWrite(2'd0, 8'h00);
    regWrite(2'd1, 8'h00);
    regWrite(2'd2, ctlb(1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    repeat (5) @(negedge clk);
    readCount(v0);
    repeat (120) @(negedge clk);
    readCount(v1);
    chk("R2 ten ticks in 120 cycles", v1 - v0, 10);
    stopAll();
    readCount(v0);
    repeat (60) @(negedge clk);
    readCount(v1);
    chk("R2 stopped holds", v1, v0);
  endtask

  task automatic t_mode16();
    logic [7:0] d;
    bit ok;
    regWrite(2'd0, 8'hFE);
    regWrite(2'd1, 8'h00);
    regWrite(2'd2, ctlb(1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    repeat (36) @(negedge clk);
    regRead(2'd1, d); chk("R3 carry into high", d, 1);
    stopAll();
    regWrite(2'd0, 8'hFE);
    regWrite(2'd1, 8'hFF);
    regWrite(2'd2, ctlb(1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    waitFlag(1'b0, 100, ok);
    chk("R3 flag on wrap", ok, 1);
    regRead(2'd0, d); chk("R3 low zero at wrap", d, 0);
    regRead(2'd1, d); chk("R3 high zero at wrap", d, 0);
    stopAll();
  endtask

  task automatic t_mode13();
    logic [7:0] d;
    bit ok;
    regWrite(2'd0, 8'h5F);
    regWrite(2'd1, 8'h05);
    regWrite(2'd2, ctlb(1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    ok = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      regRead(2'd1, d);
      if (d != 8'h05) begin ok = 1'b1; break; end
    end
    chk("R4 carry out of field", d, 8'h06);
    regRead(2'd0, d); chk("R4 field cleared upper kept", d, 8'h40);
    regWrite(2'd2, ctlb(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    regWrite(2'd0, 8'hBE);
    regWrite(2'd1, 8'hFF);
    regWrite(2'd2, ctlb(1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    waitFlag(1'b0, 100, ok);
    chk("R4 flag on 13-bit wrap", ok, 1);
    regRead(2'd0, d); chk("R4 low after wrap", d, 8'hA0);
    regRead(2'd1, d); chk("R4 high after wrap", d, 0);
    stopAll();
  endtask

  task automatic t_reload();
    logic [7:0] d;
    bit ok;
    regWrite(2'd0, 8'hFE);
    regWrite(2'd1, 8'h80);
    regWrite(2'd2, ctlb(1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    waitFlag(1'b0, 100, ok);
    chk("R5 flag on reload", ok, 1);
    regRead(2'd0, d); chk("R5 low reloaded same cycle", d, 8'h80);
    regRead(2'd1, d); chk("R5 high unchanged", d, 8'h80);
    stopAll();
  endtask

  task automatic t_flagRace();
    bit ok;
    regWrite(2'd0, 8'hFF);
    regWrite(2'd1, 8'hFF);
    regWrite(2'd2, ctlb(1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      ackNow();
      if (ovfFlag == 1'b0) break;
    end
    waitFlag(1'b0, 40, ok);
    chk("R9 overflow each tick", ok, 1);
    // now at the falling edge just after an overflow edge E
    driveWr(2'd2, ctlb(1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    chk("R9 write 0 clears", ovfFlag, 0);
    repeat (10) @(negedge clk);
    driveWr(2'd2, ctlb(1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    chk("R9 overflow beats write clear", ovfFlag, 1);
    ackNow();
    chk("R9 ack clears", ovfFlag, 0);
    repeat (10) @(negedge clk);
    ackNow();
    chk("R9 overflow beats ack", ovfFlag, 1);
    driveWr(2'd2, ctlb(1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    chk("R9 write 1 keeps flag", ovfFlag, 1);
    stopAll();
  endtask

  task automatic t_split();
    logic [7:0] d, hiRef;
    bit ok;
    regWrite(2'd0, 8'h33);
    regWrite(2'd1, 8'hFD);
    regWrite(2'd2, ctlb(1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1));
    waitFlag(1'b1, 100, ok);
    chk("R6 aux flag on high wrap", ok, 1);
    regRead(2'd1, d); chk("R6 high wrapped", d, 0);
    regRead(2'd0, d); chk("R6 low idle", d, 8'h33);
    chk("R6 main flag untouched", ovfFlag, 0);
    regWrite(2'd2, ctlb(1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    chk("R9 aux write 0 clears", ovfAuxFlag, 0);
    regWrite(2'd0, 8'hFE);
    regRead(2'd1, hiRef);
    regWrite(2'd2, ctlb(1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    waitFlag(1'b0, 100, ok);
    chk("R6 main flag on low wrap", ok, 1);
    regRead(2'd0, d); chk("R6 low wrapped", d, 0);
    regRead(2'd1, d); chk("R6 high stopped", d, hiRef);
    chk("R6 aux flag stays clear", ovfAuxFlag, 0);
    stopAll();
  endtask

  task automatic t_counter();
    int v0, v1;
    evtPin = 1'b1;
    regWrite(2'd0, 8'h00);
    regWrite(2'd1, 8'h00);
    regWrite(2'd2, ctlb(1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1));
    repeat (30) @(negedge clk);
    for (int p = 0; p < 5; p++) begin
      evtPin = 1'b0;
      repeat (30) @(negedge clk);
      evtPin = 1'b1;
      repeat (30) @(negedge clk);
    end
    readCount(v0);
    chk("R7 five pulses", v0, 5);
    repeat (100) @(negedge clk);
    readCount(v1);
    chk("R7 steady pin no count", v1, 5);
    stopAll();
  endtask

  task automatic t_gate();
    int v0, v1;
    gatePin = 1'b0;
    regWrite(2'd0, 8'h00);
    regWrite(2'd1, 8'h00);
    regWrite(2'd2, ctlb(1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1));
    readCount(v0);
    repeat (60) @(negedge clk);
    readCount(v1);
    chk("R8 gate low holds", v1, v0);
    @(negedge clk);
    gatePin = 1'b1;
    readCount(v0);
    repeat (120) @(negedge clk);
    readCount(v1);
    chk("R8 gate high counts", v1 - v0, 10);
    gatePin = 1'b0;
    regWrite(2'd2, ctlb(1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    readCount(v0);
    repeat (120) @(negedge clk);
    readCount(v1);
    chk("R8 gate ignored when off", v1 - v0, 10);
    stopAll();
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_rate();
    t_mode16();
    t_mode13();
    t_reload();
    t_flagRace();
    t_split();
    t_counter();
    t_gate();
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

endmodule